// File: doc/BRIEF.md
# Cascadable Synchronous Decade Counter

This block is a four-bit synchronous counter that runs through the decimal digits 0 to 9 and then returns to 0. Every change of state happens on the rising clock edge. The register can be cleared to zero or loaded with a four-bit value, and both of these operations are synchronous. Two count-enable inputs control whether the counter advances. Only the second of them, the carry enable, also controls the carry output.

The carry output goes high when the stage holds its last digit and its carry enable is high. Stages are chained by feeding one stage's carry output into the next stage's carry enable, and all stages share the same clock, so a row of stages counts in decimal with no ripple delay between them. A value above 9 can be loaded. The next enabled step after such a load always returns the counter to 0, so the counter cannot stay outside the decade.

Top module: `decade_stage`

## Requirements
- R1: When clearN and loadN are high and both countEn and carryEn are high, a count from 0 to 8 increases by one on the next rising edge.
- R2: When clearN and loadN are high and both enables are high, a count of 9 (binary 1001) becomes 0 on the next rising edge.
- R3: clearN low sets count to 0 on the next rising edge, whatever loadN, loadData and the enables are. Clear has the highest priority.
- R4: With clearN high, loadN low copies loadData into count on the next rising edge, whatever the enables are.
- R5: With clearN and loadN high, count keeps its value across an edge when countEn or carryEn is low.
- R6: carryOut is combinational. It is high exactly when count is 9 and carryEn is high. countEn has no effect on it, and a low carryEn forces it low even at 9.
- R7: A loaded value from 10 to 15 is held while the enables are low, and the first enabled step after it gives 0.
- R8: Two stages chained (the low stage's carryOut driving the high stage's carryEn, with shared countEn) count 00 through 99 and then wrap to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clearN | input | 1 | Synchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| countEn | input | 1 | Count enable that does not affect the carry |
| carryEn | input | 1 | Count enable that also gates carryOut |
| loadData | input | 4 | Value copied into the counter on a load |
| count | output | 4 | Present count value |
| carryOut | output | 1 | Terminal-count flag for chaining |

## Verification
Clear and load can be asserted on the same edge. Either one can also coincide with both enables being high at the terminal count, where a step would otherwise wrap. The bench drives these overlaps on purpose, for example clear and load together with a nonzero loadData, or a load of 3 while the counter sits at 9 with both enables high. It checks that the result is the value the priority order gives: 0 for a clear, loadData for a load. A cycle-by-cycle reference model also applies the priority order to a long pseudo-random stream of control inputs and compares count and carryOut on every cycle.

// File: rtl/decade_pkg.sv
package decade_pkg;

  // Exclusive strobes issued by the control decoder each cycle.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doStep;
  } ctrlStrobes_t;

endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
(
  input  logic         clearN,
  input  logic         loadN,
  input  logic         countEn,
  input  logic         carryEn,
  output ctrlStrobes_t strobes
);

  // Priority: clear, then load, then step. At most one strobe is high.
  always_comb begin
    strobes = '0;
    if (!clearN) begin
      strobes.doClear = 1'b1;
    end else if (!loadN) begin
      strobes.doLoad = 1'b1;
    end else if (countEn && carryEn) begin
      strobes.doStep = 1'b1;
    end
  end

endmodule

// File: rtl/decade_datapath.sv
module decade_datapath
  import decade_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic             carryEn,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);
  localparam bit FULL_RANGE = (LAST == (1 << WIDTH) - 1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] stepVal;
  logic             atOrAbove;

  // The wrap point is either the natural roll-over or a comparison.
  generate
    if (FULL_RANGE) begin : g_natural
      assign atOrAbove = 1'b0;
    end else begin : g_compare
      assign atOrAbove = (countQ >= LAST_V);
    end
  endgenerate

  assign stepVal = atOrAbove ? '0 : countQ + WIDTH'(1);

  always_ff @(posedge clk) begin
    if (strobes.doClear) begin
      countQ <= '0;
    end else if (strobes.doLoad) begin
      countQ <= loadData;
    end else if (strobes.doStep) begin
      countQ <= stepVal;
    end
  end

  assign count    = countQ;
  assign carryOut = carryEn && (countQ == LAST_V);

endmodule

// File: rtl/decade_stage.sv
module decade_stage
  import decade_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             countEn,
  input  logic             carryEn,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  ctrlStrobes_t strobes;

  decade_ctrl ctrl_i (
    .clearN  (clearN),
    .loadN   (loadN),
    .countEn (countEn),
    .carryEn (carryEn),
    .strobes (strobes)
  );

  decade_datapath #(
    .WIDTH (WIDTH),
    .LAST  (LAST)
  ) dp_i (
    .clk      (clk),
    .strobes  (strobes),
    .carryEn  (carryEn),
    .loadData (loadData),
    .count    (count),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/decade_stage_chk.sv
module decade_stage_chk #(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic             countEn,
  input logic             carryEn,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] count,
  input logic             carryOut
);

  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

  // The state is only defined after the first clear has taken effect.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    armed <= armed | !clearN;
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && countEn && carryEn && count < LAST_V)
      |=> count == $past(count) + WIDTH'(1));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && countEn && carryEn && count >= LAST_V) |=> count == '0);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!armed)
    !clearN |=> count == '0);

  assert_load_R4: assert property (@(posedge clk) disable iff (!armed)
    (clearN && !loadN) |=> count == $past(loadData));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && !(countEn && carryEn)) |=> $stable(count));

  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (!armed)
    !carryEn |-> !carryOut);

  assert_carry_terminal_R6: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> count == LAST_V);

endmodule

bind decade_stage decade_stage_chk #(.WIDTH(WIDTH), .LAST(LAST)) chk_i (
  .clk      (clk),
  .clearN   (clearN),
  .loadN    (loadN),
  .countEn  (countEn),
  .carryEn  (carryEn),
  .loadData (loadData),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/decade_stage_tb_top.sv
module decade_stage_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       clearN = 1'b1;
  logic       loadN = 1'b1;
  logic       countEn = 1'b0;
  logic       carryEn = 1'b0;
  logic [3:0] loadData = 4'd0;
  logic [3:0] count;
  logic       carryOut;

  // cascade pair
  logic       cClearN = 1'b1;
  logic       cEn = 1'b0;
  logic [3:0] loCount, hiCount;
  logic       loCarry, hiCarry;

  int checks = 0;
  int fails  = 0;
  int refCount = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  decade_stage dut_i (
    .clk(clk), .clearN(clearN), .loadN(loadN), .countEn(countEn),
    .carryEn(carryEn), .loadData(loadData), .count(count), .carryOut(carryOut)
  );

  decade_stage lo_i (
    .clk(clk), .clearN(cClearN), .loadN(1'b1), .countEn(cEn),
    .carryEn(cEn), .loadData(4'd0), .count(loCount), .carryOut(loCarry)
  );

  decade_stage hi_i (
    .clk(clk), .clearN(cClearN), .loadN(1'b1), .countEn(cEn),
    .carryEn(loCarry), .loadData(4'd0), .count(hiCount), .carryOut(hiCarry)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // One cycle: inputs applied now (after a falling edge), carry checked
  // before the rising edge, count checked at the next falling edge.
  task automatic cycle(input string tag, input bit cl, input bit ld,
                       input bit ce, input bit te, input int data);
    int nextVal;
    clearN = cl; loadN = ld; countEn = ce; carryEn = te; loadData = 4'(data);
    #1;
    check({tag, " carry R6"}, int'(carryOut), (refCount == 9 && te) ? 1 : 0);
    if (!cl)                nextVal = 0;
    else if (!ld)           nextVal = data;
    else if (ce && te)      nextVal = (refCount >= 9) ? 0 : refCount + 1;
    else                    nextVal = refCount;
    @(posedge clk);
    refCount = nextVal;
    @(negedge clk);
    check({tag, " count"}, int'(count), refCount);
  endtask

  initial begin
    @(negedge clk);
    // reset state via synchronous clear
    cycle("clear reset R3", 0, 1, 0, 0, 0);
    check("reset value R3", int'(count), 0);

    // R1/R2: count through the wrap
    for (int i = 0; i < 12; i++) cycle("step R1 R2", 1, 1, 1, 1, 0);

    // reach 9, hold with countEn low: carry stays high (R6), count holds (R5)
    cycle("load nine R4", 1, 0, 0, 0, 9);
    cycle("hold ce low R5", 1, 1, 0, 1, 0);
    check("carry ignores countEn R6", int'(carryOut), 1);
    cycle("hold te low R5", 1, 1, 1, 0, 0);
    check("carry gated by carryEn R6", int'(carryOut), 0);

    // priority collisions
    cycle("load beats step R4", 1, 0, 1, 1, 3);
    check("load value R4", int'(count), 3);
    cycle("clear beats load R3", 0, 0, 1, 1, 6);
    check("clear wins R3", int'(count), 0);

    // out-of-range loads (R7)
    cycle("load 12 R7", 1, 0, 0, 0, 12);
    cycle("hold 12 R7", 1, 1, 0, 1, 0);
    check("held 12 R7", int'(count), 12);
    cycle("step from 12 R7", 1, 1, 1, 1, 0);
    check("wrap from 12 R7", int'(count), 0);
    cycle("load 15 R7", 1, 0, 1, 0, 15);
    cycle("step from 15 R7", 1, 1, 1, 1, 0);
    check("wrap from 15 R7", int'(count), 0);

    // pseudo-random stream
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cycle("random R1 R3 R4 R5", lfsr[0] | lfsr[1] | lfsr[2], lfsr[3] | lfsr[4],
              lfsr[5] | lfsr[9], lfsr[6] | lfsr[10], int'(lfsr[14:11]));
      end
    end

    // cascade (R8)
    cClearN = 1'b0;
    @(posedge clk); @(negedge clk);
    cClearN = 1'b1;
    check("cascade cleared R8", int'(hiCount) * 10 + int'(loCount), 0);
    cEn = 1'b1;
    for (int i = 1; i <= 105; i++) begin
      @(posedge clk); @(negedge clk);
      check("cascade value R8", int'(hiCount) * 10 + int'(loCount), i % 100);
    end
    cEn = 1'b0;

    done = 1'b1;
  end

  initial begin
    while (!done && cycles < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG_CYCLES);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule